// File: doc/BRIEF.md
# Multi-Source CPU Clock Mode Controller

This block decides which of four clock sources (main oscillator, PLL, sub clock, on-chip oscillator) feeds the CPU clock and the flash peripheral clock. It keeps one of seven operating modes and accepts only the mode changes that the transition rules allow. The oscillators and the PLL are outside the block; each is represented only by a ready flag.

Software drives single-cycle requests: a mode change, a flash-clock source choice, a main-clock stop, and a divider write. A request that is illegal, or that names a source whose ready flag is low, leaves all state unchanged and pulses an error flag. All outputs come from registers, so each accepted request is visible one clock after the edge that samples it.

Stopping the main clock from low-speed or on-chip-oscillator mode moves the block into a matching low-power mode. On entry to low-power consumption mode, the divider is forced to the divide-by-8 code, except in one case. The exception applies when the main clock was stopped while the on-chip oscillator was driving the flash clock.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the mode is main-clock (code 0), the divider register is 01000b, both the flash clock source and the CPU source are main (code 0), and the error flag is low. Mode codes: 0 main, 1 PLL, 2 low-speed, 3 low-power, 4 on-chip oscillator, 5 on-chip-oscillator low-power, 6 main direct. Source codes: 0 main, 1 PLL, 2 sub, 3 on-chip oscillator.
- R2: A divider write is accepted only for codes 0 (/1), 2, 3, 4, 6, 8, 10, 12, 14 and 16, where the code equals the ratio. Any other code leaves the divider unchanged and raises the error flag.
- R3: In modes 0, 1, 4 and 5, the CPU source and the flash clock source are the mode's own source (main, PLL, on-chip oscillator, on-chip oscillator), and the CPU divider output equals the divider register.
- R4: From main mode, a request may go to PLL (needs PLL ready), low-speed (needs sub ready), on-chip oscillator (needs its ready) or main direct (needs PLL ready).
- R5: From low-speed mode the only request accepted is main (needs main ready). Low-power mode is reached only through the main-clock stop.
- R6: In low-speed mode the CPU source is sub with divider output 0, and a flash-source request for main, PLL or on-chip oscillator is accepted when that source is ready. In low-power mode only the on-chip oscillator may be chosen.
- R7: A main-clock stop in low-speed mode moves to low-power mode, where the CPU source stays sub and the divider output stays 0.
- R8: Entering low-power mode loads 01000b into the divider, unless the flash clock source was the on-chip oscillator at the time of the stop. In that case the divider keeps its value.
- R9: A main-clock stop in on-chip-oscillator mode moves to mode 5, which keeps the divided on-chip oscillator as the CPU clock. A stop in any mode other than 2 or 4 is illegal.
- R10: In main direct mode the CPU source is main with divider output 0, and the flash clock source is PLL.
- R11: An illegal or not-ready request changes no state and drives the error flag high for exactly the cycle after it. The flag returns low once no rejected request is present.
- R12: The exits are fixed. PLL, main direct and on-chip-oscillator modes return only to main (needs main ready). Low-power returns only to low-speed (needs main and sub ready). Mode 5 returns only to mode 4 (needs main and on-chip oscillator ready).
- R13: When requests coincide, a main-clock stop takes precedence over a mode request. A forced divide-by-8 load takes precedence over a divider write. A flash-source request in a cycle where the mode changes is dropped. Every request dropped this way raises the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_rdy | input | 1 | Main oscillator running |
| pll_rdy | input | 1 | PLL locked |
| sub_rdy | input | 1 | Sub clock running |
| oco_rdy | input | 1 | On-chip oscillator running |
| mode_req_vld | input | 1 | Mode change request strobe |
| mode_req | input | 3 | Requested mode code |
| pfc_sel_vld | input | 1 | Flash clock source request strobe |
| pfc_sel | input | 2 | Requested flash clock source code |
| main_stop | input | 1 | Main clock stop request |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | 5 | Divider code to write |
| mode | output | 3 | Current mode code |
| cpu_src | output | 2 | CPU clock source code |
| cpu_div | output | 5 | Divider code applied to the CPU clock (0 when undivided) |
| div_code | output | 5 | Divider register |
| pfc_src | output | 2 | Flash peripheral clock source code |
| req_err | output | 1 | Rejected request in the previous cycle |

## Verification
Every result appears one clock after the rising edge that samples the request: mode, sources, divider and error flag together, with no extra pipeline stage. The bench drives requests on the falling edge. After each rising edge it advances a behavioural model and compares all six outputs 1 ns later. Each comparison therefore sees exactly the state due for the request just applied. The error pulse is also checked low on the following idle cycle.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
    localparam int DIV_W     = 5;
    localparam int MAX_RATIO = 16;
    localparam logic [DIV_W-1:0] DIV_FORCED = DIV_W'(8);

    typedef enum logic [2:0] {
        M_MAIN   = 3'd0,
        M_PLL    = 3'd1,
        M_LOWSPD = 3'd2,
        M_LOWPWR = 3'd3,
        M_OCO    = 3'd4,
        M_OCO_LP = 3'd5,
        M_DIRECT = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        S_MAIN = 2'd0,
        S_PLL  = 2'd1,
        S_SUB  = 2'd2,
        S_OCO  = 2'd3
    } src_e;

    typedef struct packed {
        mode_e              mode;
        src_e               pfc;
        logic [DIV_W-1:0]   div;
        logic               err;
    } state_t;
endpackage

// File: rtl/clkmode_divchk.sv
module clkmode_divchk #(
    parameter int W         = 5,
    parameter int MAX_RATIO = 16
) (
    input  logic [W-1:0] code,
    output logic         legal
);
    localparam int NEVEN = MAX_RATIO / 2;

    logic [NEVEN-1:0] even_hit;

    for (genvar g = 0; g < NEVEN; g++) begin : g_even
        assign even_hit[g] = (code == W'(2 * (g + 1)));
    end

    assign legal = (|even_hit) || (code == W'(0)) || (code == W'(3));
endmodule

// File: rtl/clkmode_trans.sv
module clkmode_trans
    import clkmode_pkg::*;
(
    input  mode_e       cur,
    input  logic [2:0]  tgt,
    input  logic [1:0]  psel,
    input  logic        main_rdy,
    input  logic        pll_rdy,
    input  logic        sub_rdy,
    input  logic        oco_rdy,
    output logic        move_ok,
    output logic        stop_ok,
    output logic        psel_ok
);
    logic [3:0] rdy_vec;

    assign rdy_vec = {oco_rdy, sub_rdy, pll_rdy, main_rdy};

    always_comb begin
        move_ok = 1'b0;
        unique case (cur)
            M_MAIN: begin
                if (tgt == M_PLL || tgt == M_DIRECT) move_ok = pll_rdy;
                else if (tgt == M_LOWSPD)            move_ok = sub_rdy;
                else if (tgt == M_OCO)               move_ok = oco_rdy;
            end
            M_PLL, M_DIRECT, M_OCO, M_LOWSPD: begin
                move_ok = (tgt == M_MAIN) && main_rdy;
            end
            M_LOWPWR: begin
                move_ok = (tgt == M_LOWSPD) && main_rdy && sub_rdy;
            end
            M_OCO_LP: begin
                move_ok = (tgt == M_OCO) && main_rdy && oco_rdy;
            end
            default: move_ok = 1'b0;
        endcase
    end

    assign stop_ok = (cur == M_LOWSPD) || (cur == M_OCO);

    always_comb begin
        psel_ok = 1'b0;
        if (cur == M_LOWSPD)
            psel_ok = (psel != S_SUB) && rdy_vec[psel];
        else if (cur == M_LOWPWR)
            psel_ok = (psel == S_OCO) && oco_rdy;
    end
endmodule

// File: rtl/clkmode_route.sv
module clkmode_route
    import clkmode_pkg::*;
#(
    parameter int W = 5
) (
    input  mode_e         mode,
    input  logic [W-1:0]  div,
    output src_e          cpu_src,
    output logic [W-1:0]  cpu_div
);
    always_comb begin
        cpu_src = S_MAIN;
        cpu_div = div;
        unique case (mode)
            M_MAIN:             cpu_src = S_MAIN;
            M_PLL:              cpu_src = S_PLL;
            M_OCO, M_OCO_LP:    cpu_src = S_OCO;
            M_LOWSPD, M_LOWPWR: begin
                cpu_src = S_SUB;
                cpu_div = '0;
            end
            M_DIRECT: begin
                cpu_src = S_MAIN;
                cpu_div = '0;
            end
            default: begin
                cpu_src = S_MAIN;
                cpu_div = div;
            end
        endcase
    end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        main_rdy,
    input  logic        pll_rdy,
    input  logic        sub_rdy,
    input  logic        oco_rdy,
    input  logic        mode_req_vld,
    input  logic [2:0]  mode_req,
    input  logic        pfc_sel_vld,
    input  logic [1:0]  pfc_sel,
    input  logic        main_stop,
    input  logic        div_wr,
    input  logic [4:0]  div_wdata,
    output logic [2:0]  mode,
    output logic [1:0]  cpu_src,
    output logic [4:0]  cpu_div,
    output logic [4:0]  div_code,
    output logic [1:0]  pfc_src,
    output logic        req_err
);
    state_t st_d, st_q;

    logic move_ok, stop_ok, psel_ok, wr_legal;
    src_e cpu_src_w;

    clkmode_trans u_trans (
        .cur      (st_q.mode),
        .tgt      (mode_req),
        .psel     (pfc_sel),
        .main_rdy (main_rdy),
        .pll_rdy  (pll_rdy),
        .sub_rdy  (sub_rdy),
        .oco_rdy  (oco_rdy),
        .move_ok  (move_ok),
        .stop_ok  (stop_ok),
        .psel_ok  (psel_ok)
    );

    clkmode_divchk #(.W(DIV_W), .MAX_RATIO(MAX_RATIO)) u_divchk (
        .code  (div_wdata),
        .legal (wr_legal)
    );

    clkmode_route #(.W(DIV_W)) u_route (
        .mode    (st_q.mode),
        .div     (st_q.div),
        .cpu_src (cpu_src_w),
        .cpu_div (cpu_div)
    );

    logic stop_evt, move_evt, force_div;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        stop_evt = main_stop && stop_ok;
        move_evt = mode_req_vld && !main_stop && move_ok;
        force_div = stop_evt && (st_q.mode == M_LOWSPD) && (st_q.pfc != S_OCO);

        // main clock stop
        if (main_stop) begin
            if (stop_ok)
                st_d.mode = (st_q.mode == M_LOWSPD) ? M_LOWPWR : M_OCO_LP;
            else
                st_d.err = 1'b1;
        end

        // software mode request
        if (mode_req_vld) begin
            if (move_evt) begin
                st_d.mode = mode_e'(mode_req);
                unique case (mode_e'(mode_req))
                    M_MAIN:           st_d.pfc = S_MAIN;
                    M_PLL, M_DIRECT:  st_d.pfc = S_PLL;
                    M_OCO:            st_d.pfc = S_OCO;
                    default:          st_d.pfc = st_q.pfc;
                endcase
            end else begin
                st_d.err = 1'b1;
            end
        end

        // flash clock source request
        if (pfc_sel_vld) begin
            if (psel_ok && !stop_evt && !move_evt)
                st_d.pfc = src_e'(pfc_sel);
            else
                st_d.err = 1'b1;
        end

        // divider
        if (force_div) begin
            st_d.div = DIV_FORCED;
            if (div_wr) st_d.err = 1'b1;
        end else if (div_wr) begin
            if (wr_legal) st_d.div = div_wdata;
            else          st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= M_MAIN;
            st_q.pfc  <= S_MAIN;
            st_q.div  <= DIV_FORCED;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign cpu_src  = cpu_src_w;
    assign div_code = st_q.div;
    assign pfc_src  = st_q.pfc;
    assign req_err  = st_q.err;
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       div_wr,
    input logic [4:0] div_wdata,
    input logic [2:0] mode,
    input logic [1:0] cpu_src,
    input logic [4:0] cpu_div,
    input logic [4:0] div_code,
    input logic [1:0] pfc_src
);
    function automatic logic code_ok(input logic [4:0] c);
        return (c == 5'd0) || (c == 5'd3) || (!c[0] && c >= 5'd2 && c <= 5'd16);
    endfunction

    logic past_valid;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // R5
    lowspd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |=> (mode == 3'd2 || mode == 3'd0 || mode == 3'd3));

    // R8
    lp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && mode == 3'd3 && $past(mode) == 3'd2 && $past(pfc_src) != 2'd3)
        |-> (div_code == 5'd8));

    // R7
    sub_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 || mode == 3'd3) |-> (cpu_src == 2'd2 && cpu_div == 5'd0));

    // R10
    direct_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> (cpu_src == 2'd0 && cpu_div == 5'd0 && pfc_src == 2'd1));

    // R2
    div_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(div_code));

    // R2
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(div_wr) && !code_ok($past(div_wdata)) && $past(mode) != 3'd2)
        |-> $stable(div_code));
endmodule

bind clkmode_ctrl clkmode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .mode      (mode),
    .cpu_src   (cpu_src),
    .cpu_div   (cpu_div),
    .div_code  (div_code),
    .pfc_src   (pfc_src)
);

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_rdy = 1'b1, pll_rdy = 1'b0, sub_rdy = 1'b0, oco_rdy = 1'b0;
    logic mode_req_vld = 1'b0;
    logic [2:0] mode_req = '0;
    logic pfc_sel_vld = 1'b0;
    logic [1:0] pfc_sel = '0;
    logic main_stop = 1'b0;
    logic div_wr = 1'b0;
    logic [4:0] div_wdata = '0;
    logic [2:0] mode;
    logic [1:0] cpu_src;
    logic [4:0] cpu_div, div_code;
    logic [1:0] pfc_src;
    logic req_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_mode, m_div, m_pfc, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkmode_ctrl dut (.*);

    function automatic bit legal_code(int c);
        int ok[$] = '{0, 2, 3, 4, 6, 8, 10, 12, 14, 16};
        foreach (ok[i]) if (ok[i] == c) return 1;
        return 0;
    endfunction

    function automatic bit is_ready(int s);
        case (s)
            0: return main_rdy;
            1: return pll_rdy;
            2: return sub_rdy;
            default: return oco_rdy;
        endcase
    endfunction

    // allowed moves from the requirements, as "from:to" pairs with readiness
    function automatic bit move_allowed(int from, int to);
        if (from == 0) begin
            if (to == 1 || to == 6) return pll_rdy;
            if (to == 2) return sub_rdy;
            if (to == 4) return oco_rdy;
            return 0;
        end
        if (from == 1 || from == 6 || from == 4 || from == 2) return (to == 0) && main_rdy;
        if (from == 3) return (to == 2) && main_rdy && sub_rdy;
        if (from == 5) return (to == 4) && main_rdy && oco_rdy;
        return 0;
    endfunction

    function automatic int exp_cpu_src(int md);
        if (md == 1) return 1;
        if (md == 2 || md == 3) return 2;
        if (md == 4 || md == 5) return 3;
        return 0;
    endfunction

    function automatic int exp_cpu_div(int md, int dv);
        if (md == 2 || md == 3 || md == 6) return 0;
        return dv;
    endfunction

    task automatic model_advance();
        int nm = m_mode, nd = m_div, np = m_pfc, ne = 0;
        bit changed = 0;
        if (main_stop) begin
            if (m_mode == 2) begin nm = 3; changed = 1; end
            else if (m_mode == 4) begin nm = 5; changed = 1; end
            else ne = 1;
        end
        if (mode_req_vld) begin
            if (!main_stop && move_allowed(m_mode, int'(mode_req))) begin
                nm = mode_req; changed = 1;
                if (nm == 0) np = 0;
                else if (nm == 1 || nm == 6) np = 1;
                else if (nm == 4) np = 3;
            end else ne = 1;
        end
        if (pfc_sel_vld) begin
            if (changed) ne = 1;
            else if (m_mode == 2 && pfc_sel != 2 && is_ready(pfc_sel)) np = pfc_sel;
            else if (m_mode == 3 && pfc_sel == 3 && oco_rdy) np = 3;
            else ne = 1;
        end
        if (main_stop && m_mode == 2 && m_pfc != 3) begin
            nd = 8;
            if (div_wr) ne = 1;
        end else if (div_wr) begin
            if (legal_code(div_wdata)) nd = div_wdata;
            else ne = 1;
        end
        m_mode = nm; m_div = nd; m_pfc = np; m_err = ne;
    endtask

    task automatic compare(string tag);
        checks++;
        if (mode !== 3'(m_mode) || cpu_src !== 2'(exp_cpu_src(m_mode)) ||
            cpu_div !== 5'(exp_cpu_div(m_mode, m_div)) || div_code !== 5'(m_div) ||
            pfc_src !== 2'(m_pfc) || req_err !== 1'(m_err)) begin
            fails++;
            $display("FAIL %s: got mode=%0d src=%0d cdiv=%0d div=%0d pfc=%0d err=%0d exp mode=%0d src=%0d cdiv=%0d div=%0d pfc=%0d err=%0d",
                     tag, mode, cpu_src, cpu_div, div_code, pfc_src, req_err,
                     m_mode, exp_cpu_src(m_mode), exp_cpu_div(m_mode, m_div), m_div, m_pfc, m_err);
        end
    endtask

    // one clock: inputs already set after a falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model_advance();
        #1;
        compare(tag);
        @(negedge clk);
        mode_req_vld = 0; pfc_sel_vld = 0; main_stop = 0; div_wr = 0;
    endtask

    task automatic req_mode(int m, string tag);
        mode_req_vld = 1; mode_req = 3'(m); tick(tag);
        tick({tag, "_idle"});
    endtask

    task automatic req_pfc(int s, string tag);
        pfc_sel_vld = 1; pfc_sel = 2'(s); tick(tag);
        tick({tag, "_idle"});
    endtask

    task automatic wr_div(int c, string tag);
        div_wr = 1; div_wdata = 5'(c); tick(tag);
        tick({tag, "_idle"});
    endtask

    task automatic stop_main(string tag);
        main_stop = 1; tick(tag);
        tick({tag, "_idle"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_div = 8; m_pfc = 0; m_err = 0;
        repeat (3) @(negedge clk);
        #1; compare("R1_in_reset");
        rst_n = 1;
        @(negedge clk);
        tick("R1_after_reset");

        // R2 divider writes
        wr_div(3, "R2_div3");
        wr_div(5, "R2_bad5");
        wr_div(16, "R2_div16");
        wr_div(17, "R2_bad17");
        wr_div(1, "R2_bad1");
        wr_div(0, "R2_div0");
        wr_div(6, "R2_div6");

        // R11 not-ready, R4 and R3 PLL
        req_mode(1, "R11_pll_not_ready");
        pll_rdy = 1;
        req_mode(1, "R4_to_pll");
        tick("R3_pll_route");
        req_mode(4, "R12_pll_to_oco_illegal");
        stop_main("R9_stop_in_pll_illegal");
        req_mode(0, "R12_pll_to_main");

        // R10 direct
        req_mode(6, "R10_to_direct");
        wr_div(12, "R10_div_hidden");
        req_mode(0, "R12_direct_to_main");

        // low-speed path
        wr_div(4, "R2_div4");
        req_mode(2, "R11_lowspd_sub_not_ready");
        sub_rdy = 1;
        req_mode(2, "R4_to_lowspd");
        req_mode(1, "R5_lowspd_to_pll_illegal");
        req_mode(3, "R5_lowspd_to_lp_by_request_illegal");
        req_pfc(2, "R6_pfc_sub_illegal");
        req_pfc(1, "R6_pfc_pll");
        stop_main("R7_R8_stop_to_lp_forced");
        req_pfc(0, "R6_lp_pfc_main_illegal");
        main_rdy = 0;
        req_mode(2, "R12_lp_exit_main_not_ready");
        main_rdy = 1;
        req_mode(2, "R12_lp_to_lowspd");
        oco_rdy = 1;
        req_pfc(3, "R6_pfc_oco");
        wr_div(2, "R2_div2_in_lowspd");
        stop_main("R8_stop_keep_div");
        req_pfc(3, "R6_lp_pfc_oco");
        req_mode(2, "R12_lp_to_lowspd_again");
        req_pfc(0, "R6_pfc_main");

        // R13 collisions in low-speed: stop beats mode request, force beats write
        main_stop = 1; mode_req_vld = 1; mode_req = 3'd0; div_wr = 1; div_wdata = 5'd14;
        tick("R13_collision");
        tick("R13_collision_idle");
        req_mode(2, "R12_back_to_lowspd");
        mode_req_vld = 1; mode_req = 3'd0; pfc_sel_vld = 1; pfc_sel = 2'd1;
        tick("R13_pfc_dropped_on_move");
        tick("R13_pfc_dropped_idle");

        // R9 on-chip oscillator
        wr_div(10, "R2_div10");
        req_mode(4, "R3_R4_to_oco");
        stop_main("R9_stop_to_oco_lp");
        req_mode(0, "R12_oco_lp_to_main_illegal");
        req_mode(4, "R12_oco_lp_to_oco");
        req_mode(0, "R12_oco_to_main");
        stop_main("R9_stop_in_main_illegal");
        req_mode(7, "R11_undefined_mode");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule